// File: doc/BRIEF.md
# Security State Determination Table

This block classifies every incoming memory transaction as coming from a Secure or a Non-secure master. Each of several translation buffer units supplies its own sideband security index, one for the read channel and one for the write channel. Each index selects one entry in that unit's region of a shared table. Unit `u` with local index `i` maps to the 15-bit global table address `u*1024 + i`. The index width `IDX_W` is a parameter from 0 to 10, so each unit has `2^IDX_W` entries. With a width of 0, each unit has a single entry at index 0.

Every entry belongs to one of three kinds:
- fixed Secure, listed in `FSEC_ADDR`;
- programmable, listed in `PROG_ADDR` with a reset default in `PROG_DEF`;
- fixed Non-secure, which is every address not listed.

A simple programming port rewrites the programmable entries at runtime. A global override tie-off forces every result to Non-secure and refuses programming.

The configuration is checked at elaboration, and elaboration fails on any of these:
- an address that appears twice across the lists;
- a configuration with no Non-secure entry at all;
- parameters outside their legal ranges.

Top module: `ssd_table`

## Requirements
- R1: A synchronous active-high reset (`rst`) returns programmable entry k to bit k of `PROG_DEF`, where 1 means Secure.
- R2: `rd_secure[u]` and `wr_secure[u]` reflect the addressed entry in the same cycle as the valid and index inputs, with 1 meaning Secure. They are 0 whenever the matching valid bit is 0.
- R3: Unit u's index i, taken from bits `[u*IDX_W +: IDX_W]` of the index bus, looks up global address `u*1024 + i`. A write to one unit's region leaves every other unit's result unchanged.
- R4: An entry listed in `FSEC_ADDR` always reports Secure, and writes to its address have no effect.
- R5: An address in no list reports Non-secure, and writes to it have no effect.
- R6: An accepted write to a programmable address stores `prog_data` (1 means Secure). The new value is visible from the cycle after the clock edge that captured the write.
- R7: A write with `prog_secure` = 0 is refused, and the entry keeps its value.
- R8: While `sec_override` = 1, all secure outputs are 0 and writes are refused. After the override is released, the previously stored values reappear.
- R9: The read and write channels of a unit use independent indices, so both can look up different entries in the same cycle.
- R10: With `IDX_W` = 0, each unit has a single entry at offset 0 of its region, and the index input has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_override | input | 1 | Tie-off: 1 forces all results Non-secure and refuses writes |
| prog_we | input | 1 | Programming write enable |
| prog_secure | input | 1 | 1 when the programming access is a secure access |
| prog_addr | input | 15 | Global table address of the write |
| prog_data | input | 1 | Value to store, 1 = Secure |
| rd_valid | input | NUM_UNITS | Per-unit read channel valid |
| rd_idx | input | NUM_UNITS*max(IDX_W,1) | Per-unit read security index, unit 0 in the low bits |
| wr_valid | input | NUM_UNITS | Per-unit write channel valid |
| wr_idx | input | NUM_UNITS*max(IDX_W,1) | Per-unit write security index, unit 0 in the low bits |
| rd_secure | output | NUM_UNITS | Per-unit read result, 1 = Secure |
| wr_secure | output | NUM_UNITS | Per-unit write result, 1 = Secure |

## Verification
The checker assumes that `rst` is held high from time zero through at least one clock edge. It also assumes that `sec_override` and the programming inputs change only between edges, because the bank-stability properties compare values across edges. The bench drives every input on the falling edge and asserts reset at time zero. It reads the combinational results just before the next rising edge, and checks programmed values only after the capturing edge. A second instance with a zero-width index covers the single-entry case.

// File: rtl/ssd_pkg.sv
package ssd_pkg;
  localparam int ADDR_W    = 15;
  localparam int REGION_W  = 10;
  localparam int MAX_IDX_W = 10;
  localparam int MAX_UNITS = 32;

  typedef logic [ADDR_W-1:0] gaddr_t;

  function automatic gaddr_t region_base(input int unit);
    return gaddr_t'(unit) << REGION_W;
  endfunction
endpackage

// File: rtl/ssd_prog_bank.sv
module ssd_prog_bank
  import ssd_pkg::*;
#(
  parameter int NUM_PROG = 4,
  parameter logic [NUM_PROG*ADDR_W-1:0] PROG_ADDR = '0,
  parameter logic [NUM_PROG-1:0] PROG_DEF = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic                wsec,
  input  logic                override,
  input  gaddr_t              addr,
  input  logic                data,
  output logic [NUM_PROG-1:0] bank
);
  logic accept;
  assign accept = we && wsec && !override;

  always_ff @(posedge clk) begin
    if (rst) begin
      bank <= PROG_DEF;
    end else if (accept) begin
      for (int k = 0; k < NUM_PROG; k++) begin
        if (addr == PROG_ADDR[k*ADDR_W +: ADDR_W]) bank[k] <= data;
      end
    end
  end
endmodule

// File: rtl/ssd_lookup.sv
module ssd_lookup
  import ssd_pkg::*;
#(
  parameter int IDX_W    = 3,
  parameter int IDX_PW   = 3,
  parameter int UNIT     = 0,
  parameter int NUM_PROG = 4,
  parameter int NUM_FSEC = 1,
  parameter logic [NUM_PROG*ADDR_W-1:0] PROG_ADDR = '0,
  parameter logic [NUM_FSEC*ADDR_W-1:0] FSEC_ADDR = '0
) (
  input  logic                valid,
  input  logic [IDX_PW-1:0]   idx,
  input  logic                override,
  input  logic [NUM_PROG-1:0] bank,
  output logic                secure
);
  localparam gaddr_t IDX_MASK = (IDX_W == 0) ? gaddr_t'(0) : gaddr_t'((1 << IDX_W) - 1);
  localparam gaddr_t BASE     = region_base(UNIT);

  gaddr_t addr;
  logic   fixed_sec;
  logic   prog_sec;

  always_comb begin
    addr      = BASE | (gaddr_t'(idx) & IDX_MASK);
    fixed_sec = 1'b0;
    prog_sec  = 1'b0;
    for (int f = 0; f < NUM_FSEC; f++) begin
      if (addr == FSEC_ADDR[f*ADDR_W +: ADDR_W]) fixed_sec = 1'b1;
    end
    for (int k = 0; k < NUM_PROG; k++) begin
      if (addr == PROG_ADDR[k*ADDR_W +: ADDR_W]) prog_sec = bank[k];
    end
    secure = valid && !override && (fixed_sec || prog_sec);
  end
endmodule

// File: rtl/ssd_table.sv
module ssd_table
  import ssd_pkg::*;
#(
  parameter int NUM_UNITS = 2,
  parameter int IDX_W     = 3,
  parameter int NUM_PROG  = 4,
  parameter int NUM_FSEC  = 2,
  parameter logic [NUM_PROG*15-1:0] PROG_ADDR =
    {15'h0407, 15'h0402, 15'h0005, 15'h0001},
  parameter logic [NUM_PROG-1:0] PROG_DEF = 4'b0101,
  parameter logic [NUM_FSEC*15-1:0] FSEC_ADDR = {15'h0403, 15'h0000},
  localparam int IDX_PW = (IDX_W > 0) ? IDX_W : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        sec_override,
  input  logic                        prog_we,
  input  logic                        prog_secure,
  input  logic [14:0]                 prog_addr,
  input  logic                        prog_data,
  input  logic [NUM_UNITS-1:0]        rd_valid,
  input  logic [NUM_UNITS*IDX_PW-1:0] rd_idx,
  input  logic [NUM_UNITS-1:0]        wr_valid,
  input  logic [NUM_UNITS*IDX_PW-1:0] wr_idx,
  output logic [NUM_UNITS-1:0]        rd_secure,
  output logic [NUM_UNITS-1:0]        wr_secure
);
  localparam int ENTRIES = NUM_UNITS * (1 << IDX_W);

  function automatic bit cfg_ok();
    bit ok;
    bit has_ns;
    ok = (IDX_W >= 0) && (IDX_W <= MAX_IDX_W) && (NUM_PROG >= 1) && (NUM_PROG <= 32)
         && (NUM_UNITS >= 1) && (NUM_UNITS <= MAX_UNITS);
    for (int a = 0; a < NUM_PROG; a++) begin
      for (int b = a + 1; b < NUM_PROG; b++)
        if (PROG_ADDR[a*ADDR_W +: ADDR_W] == PROG_ADDR[b*ADDR_W +: ADDR_W]) ok = 0;
      for (int f = 0; f < NUM_FSEC; f++)
        if (PROG_ADDR[a*ADDR_W +: ADDR_W] == FSEC_ADDR[f*ADDR_W +: ADDR_W]) ok = 0;
    end
    for (int f = 0; f < NUM_FSEC; f++)
      for (int g = f + 1; g < NUM_FSEC; g++)
        if (FSEC_ADDR[f*ADDR_W +: ADDR_W] == FSEC_ADDR[g*ADDR_W +: ADDR_W]) ok = 0;
    has_ns = (ENTRIES > NUM_PROG + NUM_FSEC) || (PROG_DEF != {NUM_PROG{1'b1}});
    return ok && has_ns;
  endfunction

  localparam bit CFG_OK = cfg_ok();

  generate
    if (!CFG_OK) begin : g_bad_cfg
      $error("ssd_table: illegal security table configuration");
    end
  endgenerate

  logic [NUM_PROG-1:0] bank;

  ssd_prog_bank #(
    .NUM_PROG (NUM_PROG),
    .PROG_ADDR(PROG_ADDR),
    .PROG_DEF (PROG_DEF)
  ) u_bank (
    .clk     (clk),
    .rst     (rst),
    .we      (prog_we),
    .wsec    (prog_secure),
    .override(sec_override),
    .addr    (prog_addr),
    .data    (prog_data),
    .bank    (bank)
  );

  genvar u;
  generate
    for (u = 0; u < NUM_UNITS; u++) begin : g_unit
      ssd_lookup #(
        .IDX_W(IDX_W), .IDX_PW(IDX_PW), .UNIT(u),
        .NUM_PROG(NUM_PROG), .NUM_FSEC(NUM_FSEC),
        .PROG_ADDR(PROG_ADDR), .FSEC_ADDR(FSEC_ADDR)
      ) u_rd (
        .valid   (rd_valid[u]),
        .idx     (rd_idx[u*IDX_PW +: IDX_PW]),
        .override(sec_override),
        .bank    (bank),
        .secure  (rd_secure[u])
      );
      ssd_lookup #(
        .IDX_W(IDX_W), .IDX_PW(IDX_PW), .UNIT(u),
        .NUM_PROG(NUM_PROG), .NUM_FSEC(NUM_FSEC),
        .PROG_ADDR(PROG_ADDR), .FSEC_ADDR(FSEC_ADDR)
      ) u_wr (
        .valid   (wr_valid[u]),
        .idx     (wr_idx[u*IDX_PW +: IDX_PW]),
        .override(sec_override),
        .bank    (bank),
        .secure  (wr_secure[u])
      );
    end
  endgenerate
endmodule

// File: rtl/ssd_table_chk.sv
module ssd_table_chk #(
  parameter int NUM_UNITS = 2,
  parameter int NUM_PROG  = 4,
  parameter logic [NUM_PROG-1:0] PROG_DEF = '0
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 sec_override,
  input logic                 prog_we,
  input logic                 prog_secure,
  input logic [NUM_UNITS-1:0] rd_valid,
  input logic [NUM_UNITS-1:0] wr_valid,
  input logic [NUM_UNITS-1:0] rd_secure,
  input logic [NUM_UNITS-1:0] wr_secure,
  input logic [NUM_PROG-1:0]  bank
);
  p_reset_defaults_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> bank == PROG_DEF);

  p_valid_gate_r2: assert property (@(posedge clk) disable iff (rst)
    ((rd_secure & ~rd_valid) == '0) && ((wr_secure & ~wr_valid) == '0));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !prog_we |=> $stable(bank));

  p_nonsec_refused_r7: assert property (@(posedge clk) disable iff (rst)
    prog_we && !prog_secure |=> $stable(bank));

  p_override_ns_r8: assert property (@(posedge clk) disable iff (rst)
    sec_override |-> (rd_secure == '0) && (wr_secure == '0));

  p_override_refused_r8: assert property (@(posedge clk) disable iff (rst)
    prog_we && sec_override |=> $stable(bank));
endmodule

bind ssd_table ssd_table_chk #(
  .NUM_UNITS(NUM_UNITS),
  .NUM_PROG (NUM_PROG),
  .PROG_DEF (PROG_DEF)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sec_override(sec_override),
  .prog_we     (prog_we),
  .prog_secure (prog_secure),
  .rd_valid    (rd_valid),
  .wr_valid    (wr_valid),
  .rd_secure   (rd_secure),
  .wr_secure   (wr_secure),
  .bank        (bank)
);

// File: tb/tb_ssd_table.sv
`timescale 1ns/1ps
module tb_ssd_table;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        ovr = 1'b0, we = 1'b0, wsec = 1'b0, wdata = 1'b0;
  logic [14:0] waddr = '0;
  logic [1:0]  rv = '0, wv = '0, rs, ws;
  logic [5:0]  ri = '0, wi = '0;
  logic [1:0]  rv0 = '0, wv0 = '0, rs0, ws0;
  logic [1:0]  ri0 = '0, wi0 = '0;

  // Defaults: unit0 idx0 fixed S, idx1 prog S, idx5 prog NS;
  //           unit1 idx2 prog S, idx3 fixed S, idx7 prog NS; rest fixed NS.
  ssd_table dut (
    .clk(clk), .rst(rst), .sec_override(ovr), .prog_we(we), .prog_secure(wsec),
    .prog_addr(waddr), .prog_data(wdata), .rd_valid(rv), .rd_idx(ri),
    .wr_valid(wv), .wr_idx(wi), .rd_secure(rs), .wr_secure(ws)
  );

  // Zero-width index: unit0 entry fixed S, unit1 entry programmable default NS.
  ssd_table #(
    .NUM_UNITS(2), .IDX_W(0), .NUM_PROG(1), .NUM_FSEC(1),
    .PROG_ADDR(15'h0400), .PROG_DEF(1'b0), .FSEC_ADDR(15'h0000)
  ) dut0 (
    .clk(clk), .rst(rst), .sec_override(ovr), .prog_we(we), .prog_secure(wsec),
    .prog_addr(waddr), .prog_data(wdata), .rd_valid(rv0), .rd_idx(ri0),
    .wr_valid(wv0), .wr_idx(wi0), .rd_secure(rs0), .wr_secure(ws0)
  );

  int tests = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic look(input logic [1:0] v_r, input logic [5:0] i_r,
                      input logic [1:0] v_w, input logic [5:0] i_w);
    @(negedge clk);
    rv = v_r; ri = i_r; wv = v_w; wi = i_w;
    #1;
  endtask

  task automatic prog(input logic [14:0] a, input logic d, input logic s);
    @(negedge clk);
    we = 1'b1; waddr = a; wdata = d; wsec = s;
    @(negedge clk);
    we = 1'b0; wsec = 1'b0;
  endtask

  // {rv, ri{u1,u0}, wv, wi{u1,u0}, exp_rd, exp_wr} against reset defaults
  localparam int NV = 6;
  localparam logic [19:0] VEC [NV] = '{
    {2'b11, 3'd3, 3'd0, 2'b11, 3'd0, 3'd2, 2'b11, 2'b00},
    {2'b01, 3'd2, 3'd1, 2'b10, 3'd2, 3'd1, 2'b01, 2'b10},
    {2'b11, 3'd7, 3'd5, 2'b11, 3'd3, 3'd1, 2'b00, 2'b11},
    {2'b00, 3'd3, 3'd0, 2'b11, 3'd2, 3'd7, 2'b00, 2'b10},
    {2'b11, 3'd1, 3'd3, 2'b01, 3'd6, 3'd0, 2'b00, 2'b01},
    {2'b10, 3'd6, 3'd0, 2'b10, 3'd3, 3'd0, 2'b00, 2'b10}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 R2 R3 R4 R5 R9: table of default lookups
    for (int n = 0; n < NV; n++) begin
      look(VEC[n][19:18], VEC[n][17:12], VEC[n][11:10], VEC[n][9:4]);
      chk($sformatf("R2/R9 vec%0d rd", n), rs, VEC[n][3:2]);
      chk($sformatf("R1/R3 vec%0d wr", n), ws, VEC[n][1:0]);
    end

    // R6: accepted writes take effect after the capturing edge
    prog(15'h0005, 1'b1, 1'b1);
    prog(15'h0001, 1'b0, 1'b1);
    look(2'b01, {3'd0, 3'd5}, 2'b01, {3'd0, 3'd1});
    chk("R6 write secure to u0 idx5", rs, 2'b01);
    chk("R6 write nonsecure to u0 idx1", ws, 2'b00);

    // R7: nonsecure access refused
    prog(15'h0407, 1'b1, 1'b0);
    look(2'b10, {3'd7, 3'd0}, 2'b00, 6'd0);
    chk("R7 refused write u1 idx7", rs, 2'b00);

    // R8: override forces NS and refuses writes
    @(negedge clk); ovr = 1'b1;
    look(2'b11, {3'd3, 3'd0}, 2'b11, {3'd2, 3'd5});
    chk("R8 override rd", rs, 2'b00);
    chk("R8 override wr", ws, 2'b00);
    prog(15'h0407, 1'b1, 1'b1);
    @(negedge clk); ovr = 1'b0;
    look(2'b10, {3'd7, 3'd0}, 2'b11, {3'd2, 3'd5});
    chk("R8 write during override refused", rs, 2'b00);
    chk("R8 stored values return", ws, 2'b11);

    // R4: fixed secure entries ignore writes
    prog(15'h0000, 1'b0, 1'b1);
    prog(15'h0403, 1'b0, 1'b1);
    look(2'b11, {3'd3, 3'd0}, 2'b00, 6'd0);
    chk("R4 fixed secure unchanged", rs, 2'b11);

    // R5: unlisted entries ignore writes
    prog(15'h0003, 1'b1, 1'b1);
    prog(15'h0406, 1'b1, 1'b1);
    look(2'b11, {3'd6, 3'd3}, 2'b00, 6'd0);
    chk("R5 unlisted stays NS", rs, 2'b00);

    // R3: region isolation
    prog(15'h0407, 1'b1, 1'b1);
    look(2'b11, {3'd7, 3'd7}, 2'b11, {3'd2, 3'd2});
    chk("R3 u1 idx7 set, u0 idx7 not", rs, 2'b10);
    chk("R3 idx2 per region", ws, 2'b10);

    // R1: reset restores defaults
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    look(2'b11, {3'd7, 3'd5}, 2'b01, {3'd0, 3'd1});
    chk("R1 defaults restored rd", rs, 2'b00);
    chk("R1 defaults restored wr", ws, 2'b01);

    // R10: zero-width index
    @(negedge clk); rv0 = 2'b11; wv0 = 2'b11; ri0 = 2'b00; wi0 = 2'b11; #1;
    chk("R10 single entry default", rs0, 2'b01);
    chk("R10 index ignored", ws0, 2'b01);
    prog(15'h0400, 1'b1, 1'b1);
    #1;
    chk("R10 unit1 entry programmed", rs0, 2'b11);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule